// File: doc/BRIEF.md
# Subroutine Call, Return, Jump and Restart Sequencer

This unit carries out the control-transfer instructions of an 8-bit processor. The processor has a 16-bit program counter and a 16-bit stack pointer, and its stack lives in byte-wide memory. The surrounding core fetches an opcode and advances the program counter past it. It then presents the opcode, the current program counter and the current stack pointer with a one-cycle `start` strobe. The unit reads any 16-bit operand, pushes or pops the return address through its memory port, and leaves the new program counter and stack pointer on its outputs when it pulses `done`.

Four kinds of transfer are handled:
- **Absolute jump:** loads the program counter from a little-endian immediate.
- **Call:** reads the immediate target, pushes the address of the byte after that operand, then jumps.
- **Return:** pops the program counter.
- **Restart:** eight one-byte opcodes that push the current program counter and jump to a fixed low vector.

Any other opcode completes at once and changes nothing. The stack grows downward, two bytes per push. Every byte transfer takes one memory cycle, and the read port returns data in the same cycle as the address.

Top module: `crx_xfer_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0, and `pc_out` and `sp_out` are 0x0000.
- R2: Opcode 0xC3 reads the low target byte at PC and the high byte at PC+1, sets `pc_out` to {high,low}, leaves `sp_out` equal to SP, writes no memory, and raises `done` 3 cycles after the start edge.
- R3: Opcode 0xCD reads a little-endian target at PC and PC+1 and pushes the return address PC+2. It sets `pc_out` to the target and `sp_out` to SP-2, and raises `done` 5 cycles after the start edge.
- R4: A push writes the high byte of the return address at SP-1 in one cycle and the low byte at SP-2 in the next cycle.
- R5: An opcode whose bits [7:6] and [2:0] are all ones is a restart. It pushes the incoming PC, sets `pc_out` to bits [5:3] times 8 (0x00 to 0x38), sets `sp_out` to SP-2, and raises `done` 3 cycles after the start edge.
- R6: Opcode 0xC9 reads the low byte at SP and the high byte at SP+1, sets `pc_out` to {high,low} and `sp_out` to SP+2, writes no memory, and raises `done` 3 cycles after the start edge.
- R7: Any other opcode accesses no memory, returns `pc_out` = PC and `sp_out` = SP, and raises `done` 1 cycle after the start edge.
- R8: All PC and SP address arithmetic wraps modulo 2^16. This covers a push at SP 0x0001, a pop at SP 0xFFFF, and a call whose operand starts at 0xFFFF.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after the start edge through the `done` cycle. `start` is ignored while `busy` is high. Memory is accessed only while `busy` is high.
- R10: While the unit is idle and `start` is low, `pc_out` and `sp_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin executing `opcode`, sampled while idle |
| opcode | input | 8 | Opcode of the transfer instruction |
| pc_in | input | 16 | Program counter, already past the opcode |
| sp_in | input | 16 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 16 | Resulting stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read this cycle |
| mem_wr | output | 1 | Memory write this cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data for `mem_addr`, same cycle |

## Verification
The bench builds the unit with its default parameters: a byte width of 8, which gives 16-bit program counter and stack pointer, and a vector shift of 3. With a 16-bit address space, the wrap of the stack pointer and of the call operand across 0xFFFF/0x0000 takes only a few operations to reach. All eight restart vectors are checked against the multiply-by-8 spacing. The bench memory model decodes only the low address byte, so each test places its operand and stack bytes at distinct low bytes. The bench logs every read and write address to check byte order and cycle counts.

// File: rtl/crx_pkg.sv
package crx_pkg;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_JUMP,
    XK_CALL,
    XK_RET,
    XK_RST
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPR_LO,
    ST_OPR_HI,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_FIN
  } xfer_state_e;

  localparam logic [7:0] OPC_JUMP  = 8'hC3;
  localparam logic [7:0] OPC_CALL  = 8'hCD;
  localparam logic [7:0] OPC_RET   = 8'hC9;
  localparam logic [7:0] RST_MASK  = 8'hC7;
  localparam logic [7:0] RST_MATCH = 8'hC7;

endpackage

// File: rtl/crx_rst_sync.sv
module crx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/crx_decode.sv
module crx_decode
  import crx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int VEC_SHIFT = 3,
  localparam int ADDR_W   = 2 * BYTE_W
) (
  input  logic [7:0]        opcode,
  output xfer_kind_e        kind,
  output logic [ADDR_W-1:0] vector
);

  always_comb begin
    kind = XK_NONE;
    if (opcode == OPC_JUMP)                     kind = XK_JUMP;
    else if (opcode == OPC_CALL)                kind = XK_CALL;
    else if (opcode == OPC_RET)                 kind = XK_RET;
    else if ((opcode & RST_MASK) == RST_MATCH)  kind = XK_RST;
  end

  // restart target: opcode field [5:3] scaled by the vector stride
  assign vector = {{(ADDR_W-3){1'b0}}, opcode[5:3]} << VEC_SHIFT;

endmodule

// File: rtl/crx_seq.sv
module crx_seq
  import crx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_kind_e  kind_in,
  output xfer_state_e state,
  output xfer_kind_e  kind_q,
  output logic        busy,
  output logic        done
);

  xfer_state_e state_d;
  xfer_kind_e  kind_d;
  logic        kind_en;

  always_comb begin
    state_d = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          case (kind_in)
            XK_JUMP, XK_CALL: state_d = ST_OPR_LO;
            XK_RST:           state_d = ST_PUSH_HI;
            XK_RET:           state_d = ST_POP_LO;
            default:          state_d = ST_FIN;
          endcase
        end
      end
      ST_OPR_LO:  state_d = ST_OPR_HI;
      ST_OPR_HI:  state_d = (kind_q == XK_CALL) ? ST_PUSH_HI : ST_FIN;
      ST_PUSH_HI: state_d = ST_PUSH_LO;
      ST_PUSH_LO: state_d = ST_FIN;
      ST_POP_LO:  state_d = ST_POP_HI;
      ST_POP_HI:  state_d = ST_FIN;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign kind_en = start && (state == ST_IDLE);
  assign kind_d  = kind_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= XK_NONE;
    end else begin
      state <= state_d;
      if (kind_en) kind_q <= kind_d;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

// File: rtl/crx_path.sv
module crx_path
  import crx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  xfer_state_e       state,
  input  xfer_kind_e        kind_q,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [ADDR_W-1:0] vector,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata
);

  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_d, sp_d, tgt_q, tgt_d;
  logic [ADDR_W-1:0] pc_inc1, pc_inc2, sp_inc1, sp_inc2, sp_dec1, sp_dec2;
  logic              upd_en;

  assign pc_inc1 = pc_q + STEP1;
  assign pc_inc2 = pc_q + STEP2;
  assign sp_inc1 = sp_q + STEP1;
  assign sp_inc2 = sp_q + STEP2;
  assign sp_dec1 = sp_q - STEP1;
  assign sp_dec2 = sp_q - STEP2;

  always_comb begin
    pc_d  = pc_q;
    sp_d  = sp_q;
    tgt_d = tgt_q;
    if (load) begin
      pc_d  = pc_in;
      sp_d  = sp_in;
      tgt_d = vector;
    end else begin
      case (state)
        ST_OPR_LO: tgt_d[BYTE_W-1:0] = mem_rdata;
        ST_OPR_HI: begin
          if (kind_q == XK_CALL) begin
            tgt_d[ADDR_W-1:BYTE_W] = mem_rdata;
            pc_d = pc_inc2;
          end else begin
            pc_d = {mem_rdata, tgt_q[BYTE_W-1:0]};
          end
        end
        ST_PUSH_LO: begin
          sp_d = sp_dec2;
          pc_d = tgt_q;
        end
        ST_POP_LO: tgt_d[BYTE_W-1:0] = mem_rdata;
        ST_POP_HI: begin
          pc_d = {mem_rdata, tgt_q[BYTE_W-1:0]};
          sp_d = sp_inc2;
        end
        default: ;
      endcase
    end
  end

  assign upd_en = load || (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      tgt_q <= '0;
    end else if (upd_en) begin
      pc_q  <= pc_d;
      sp_q  <= sp_d;
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    case (state)
      ST_OPR_LO:  begin mem_addr = pc_q;    mem_rd = 1'b1; end
      ST_OPR_HI:  begin mem_addr = pc_inc1; mem_rd = 1'b1; end
      ST_POP_LO:  begin mem_addr = sp_q;    mem_rd = 1'b1; end
      ST_POP_HI:  begin mem_addr = sp_inc1; mem_rd = 1'b1; end
      ST_PUSH_HI: begin
        mem_addr  = sp_dec1;
        mem_wr    = 1'b1;
        mem_wdata = pc_q[ADDR_W-1:BYTE_W];
      end
      ST_PUSH_LO: begin
        mem_addr  = sp_dec2;
        mem_wr    = 1'b1;
        mem_wdata = pc_q[BYTE_W-1:0];
      end
      default: ;
    endcase
  end

  // R4
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - STEP1));

  // R6
  read_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + STEP1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !load) |=> ($stable(pc_q) && $stable(sp_q)));

endmodule

// File: rtl/crx_xfer_unit.sv
module crx_xfer_unit
  import crx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int VEC_SHIFT = 3,
  localparam int ADDR_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  logic              rst_int_n;
  logic              accept;
  xfer_kind_e        kind_dec, kind_q;
  xfer_state_e       state;
  logic [ADDR_W-1:0] vector;

  crx_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  crx_decode #(.BYTE_W(BYTE_W), .VEC_SHIFT(VEC_SHIFT)) u_dec (
    .opcode(opcode),
    .kind  (kind_dec),
    .vector(vector)
  );

  assign accept = start && !busy;

  crx_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (accept),
    .kind_in(kind_dec),
    .state  (state),
    .kind_q (kind_q),
    .busy   (busy),
    .done   (done)
  );

  crx_path #(.BYTE_W(BYTE_W)) u_path (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (accept),
    .state    (state),
    .kind_q   (kind_q),
    .pc_in    (pc_in),
    .sp_in    (sp_in),
    .vector   (vector),
    .mem_rdata(mem_rdata),
    .pc_q     (pc_out),
    .sp_q     (sp_out),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_wdata(mem_wdata)
  );

  // R9
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd || mem_wr) |-> busy);

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mem_rd && mem_wr));

endmodule

// File: tb/test_crx_xfer_unit.sv
module test_crx_xfer_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] pc_in = 16'h0, sp_in = 16'h0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] pc_out, sp_out, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0]  mem [256];
  logic [15:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  logic [15:0] rlog_a [16];
  int wn = 0, rn = 0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  crx_xfer_unit i_crx_xfer_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .pc_in(pc_in), .sp_in(sp_in), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wlog_a[wn % 16] <= mem_addr;
      wlog_d[wn % 16] <= mem_wdata;
      wn <= wn + 1;
    end
    if (mem_rd) begin
      rlog_a[rn % 16] <= mem_addr;
      rn <= rn + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  int wb, rb, lat;

  task automatic run_op(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] sp);
    @(negedge clk);
    wb = wn; rb = rn;
    opcode = op; pc_in = pc; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic test_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "mem_rd", mem_rd, 0);
    chk("R1", "mem_wr", mem_wr, 0);
    chk("R1", "pc_out", pc_out, 0);
    chk("R1", "sp_out", sp_out, 0);
  endtask

  task automatic test_jump();
    mem[8'h34] = 8'h5A; mem[8'h35] = 8'hA7;
    run_op(8'hC3, 16'h1234, 16'h4321);
    chk("R2", "latency", lat, 3);
    chk("R2", "pc_out", pc_out, 16'hA75A);
    chk("R2", "sp_out", sp_out, 16'h4321);
    chk("R2", "writes", wn - wb, 0);
    chk("R2", "reads", rn - rb, 2);
    chk("R2", "read0 addr", rlog_a[rb % 16], 16'h1234);
    chk("R2", "read1 addr", rlog_a[(rb + 1) % 16], 16'h1235);
  endtask

  task automatic test_call();
    mem[8'h00] = 8'h50; mem[8'h01] = 8'h31;
    run_op(8'hCD, 16'h2000, 16'hD0F0);
    chk("R3", "latency", lat, 5);
    chk("R3", "pc_out", pc_out, 16'h3150);
    chk("R3", "sp_out", sp_out, 16'hD0EE);
    chk("R3", "writes", wn - wb, 2);
    chk("R4", "push hi addr", wlog_a[wb % 16], 16'hD0EF);
    chk("R4", "push hi data", wlog_d[wb % 16], 8'h20);
    chk("R4", "push lo addr", wlog_a[(wb + 1) % 16], 16'hD0EE);
    chk("R4", "push lo data", wlog_d[(wb + 1) % 16], 8'h02);
  endtask

  task automatic test_restart();
    for (int i = 0; i < 8; i++) begin
      run_op(8'hC7 | 8'(i << 3), 16'h0150 + 16'(i), 16'hC000);
      chk("R5", "latency", lat, 3);
      chk("R5", "vector", pc_out, 16'(i * 8));
      chk("R5", "sp_out", sp_out, 16'hBFFE);
      chk("R4", "push hi", {wlog_a[wb % 16], wlog_d[wb % 16]}, {16'hBFFF, 8'h01});
      chk("R4", "push lo", {wlog_a[(wb + 1) % 16], wlog_d[(wb + 1) % 16]},
          {16'hBFFE, 8'(8'h50 + i)});
    end
  endtask

  task automatic test_ret();
    mem[8'h10] = 8'h9C; mem[8'h11] = 8'h4E;
    run_op(8'hC9, 16'h0777, 16'h7010);
    chk("R6", "latency", lat, 3);
    chk("R6", "pc_out", pc_out, 16'h4E9C);
    chk("R6", "sp_out", sp_out, 16'h7012);
    chk("R6", "writes", wn - wb, 0);
    chk("R6", "read order", {rlog_a[rb % 16], rlog_a[(rb + 1) % 16]}, {16'h7010, 16'h7011});
  endtask

  task automatic test_other();
    logic [7:0] ops [4] = '{8'h00, 8'hC8, 8'hCB, 8'hC6};
    for (int i = 0; i < 4; i++) begin
      run_op(ops[i], 16'h6600 + 16'(i), 16'h9900 - 16'(i));
      chk("R7", "latency", lat, 1);
      chk("R7", "pc_out", pc_out, 16'h6600 + 16'(i));
      chk("R7", "sp_out", sp_out, 16'h9900 - 16'(i));
      chk("R7", "mem accesses", (wn - wb) + (rn - rb), 0);
    end
  endtask

  task automatic test_wrap();
    run_op(8'hFF, 16'hABCD, 16'h0001);
    chk("R8", "rst pc", pc_out, 16'h0038);
    chk("R8", "push sp", sp_out, 16'hFFFF);
    chk("R8", "push hi", {wlog_a[wb % 16], wlog_d[wb % 16]}, {16'h0000, 8'hAB});
    chk("R8", "push lo", {wlog_a[(wb + 1) % 16], wlog_d[(wb + 1) % 16]}, {16'hFFFF, 8'hCD});
    run_op(8'hC9, 16'h0038, 16'hFFFF);
    chk("R8", "pop pc", pc_out, 16'hABCD);
    chk("R8", "pop sp", sp_out, 16'h0001);
    chk("R8", "pop hi addr", rlog_a[(rb + 1) % 16], 16'h0000);
    mem[8'hFF] = 8'h22; mem[8'h00] = 8'h11;
    run_op(8'hCD, 16'hFFFF, 16'h3000);
    chk("R8", "call pc", pc_out, 16'h1122);
    chk("R8", "call ret addr", {wlog_d[wb % 16], wlog_d[(wb + 1) % 16]}, 16'h0001);
    chk("R8", "operand hi addr", rlog_a[(rb + 1) % 16], 16'h0000);
  endtask

  task automatic test_busy_ignore();
    mem[8'h40] = 8'h0D; mem[8'h41] = 8'hF0;
    @(negedge clk);
    wb = wn;
    opcode = 8'hCD; pc_in = 16'h8040; sp_in = 16'h5000; start = 1'b1;
    @(negedge clk);
    chk("R9", "busy after start", busy, 1);
    opcode = 8'h00; pc_in = 16'h5555; sp_in = 16'h1111;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    chk("R9", "latency with start held", lat, 5);
    chk("R9", "busy at done", busy, 1);
    chk("R9", "pc_out", pc_out, 16'hF00D);
    chk("R9", "sp_out", sp_out, 16'h4FFE);
    @(negedge clk);
    chk("R9", "done one cycle", done, 0);
    chk("R9", "idle after done", busy, 0);
  endtask

  task automatic test_hold();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pc_in = 16'h1000 * 16'(i + 1); sp_in = ~pc_in;
    end
    chk("R10", "pc held", pc_out, 16'hF00D);
    chk("R10", "sp held", sp_out, 16'h4FFE);
    chk("R10", "no access", {mem_rd, mem_wr}, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_jump();
    test_call();
    test_restart();
    test_ret();
    test_other();
    test_wrap();
    test_busy_ignore();
    test_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule